// File: doc/BRIEF.md
# Early Load Retirement Controller with Checkpoint Rollback

This block sits at the retirement stage of an out-of-order core. It watches the instruction at the head of the reorder buffer. When that instruction is a long-latency load whose data has not arrived, the block keeps it from blocking retirement. It takes a snapshot of the architectural registers, hands a predicted load value to the load's consumers, and then lets the load retire. Younger instructions can then keep retiring past it.

Every load retired this way leaves a pending record. The record holds the load's tag, the predicted value and the index of the checkpoint taken for it. When memory returns the true data, the record is found by tag and the data is compared with the prediction. A match marks the record good. Good records release their checkpoints strictly from oldest to youngest. A mismatch sends a one-cycle rollback request, with a pipeline flush, that names the load's checkpoint. In the same cycle the failing record and every younger record are dropped.

The predictor, the register file and the memory system are outside the block. The block only exchanges requests and values with them through its ports.

Top module: `elr_top`

## Requirements
- R1: A checkpoint is taken only for a head entry that is valid, is a load, is flagged long-latency and is unresolved. Any other head entry causes no `ckpt_take` and no `hold_head`.
- R2: For a qualifying head, `ckpt_take` pulses in the cycle after the head is seen. `fwd_valid` follows in the next cycle, carrying the latched head tag and predicted value. `retire_early` pulses in the cycle after that. `hold_head` is high in all three cycles and low once the sequence ends.
- R3: At most NUM_CKPT (default 4) checkpoints are outstanding. While all slots are in use, a qualifying head gets no `ckpt_take` and `hold_head` stays high.
- R4: Checkpoint indices are handed out in ring order 0, 1, ..., NUM_CKPT-1, 0, and so on, continuing from the last index allocated.
- R5: A return is matched to a pending record by its tag. A return whose tag matches no live, unchecked record has no effect on any output.
- R6: A correct return marks its record good. `ckpt_free` pulses once per cycle with the index of the oldest record, and only when that record is good. The first pulse comes in the cycle after the return, so a good record waits for every older record to be freed.
- R7: A mismatching return raises `rollback` and `flush` together for exactly one cycle, starting the cycle after the return. `rollback_idx` is that load's checkpoint index.
- R8: A rollback to index k drops record k and every younger record. Later returns carrying their tags have no effect, and the next checkpoint taken reuses index k.
- R9: `spec_mode` is high from the cycle after a `ckpt_take` until no checkpoint is outstanding.
- R10: A mismatch arriving while an entry sequence is under way abandons that sequence. The remaining `ckpt_take`, `fwd_valid` and `retire_early` pulses of the sequence do not appear, and no new sequence starts in the rollback cycle.
- R11: After reset every output is low and no checkpoint is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Reorder buffer head holds an instruction |
| head_is_load | input | 1 | Head instruction is a load |
| head_long_lat | input | 1 | Head load is known to be long-latency |
| head_resolved | input | 1 | Head load data has arrived |
| head_tag | input | TAG_W | Tag of the head load |
| head_pred | input | DATA_W | Predicted value for the head load |
| hold_head | output | 1 | Head must not retire normally this cycle |
| ckpt_take | output | 1 | Take a register checkpoint now |
| ckpt_take_idx | output | IDX_W | Slot for the checkpoint being taken |
| fwd_valid | output | 1 | Predicted value offered to consumers |
| fwd_tag | output | TAG_W | Tag of the load being predicted |
| fwd_value | output | DATA_W | Predicted value |
| retire_early | output | 1 | Retire the head load now |
| ret_valid | input | 1 | Memory returns data this cycle |
| ret_tag | input | TAG_W | Tag of returning load |
| ret_data | input | DATA_W | Returned data |
| ckpt_free | output | 1 | Release a checkpoint |
| ckpt_free_idx | output | IDX_W | Slot being released |
| rollback | output | 1 | Restore registers from a checkpoint |
| rollback_idx | output | IDX_W | Checkpoint to restore |
| flush | output | 1 | Discard all younger pipeline work |
| spec_mode | output | 1 | At least one checkpoint outstanding |

## Verification
The bench fills all four slots and presents a fifth load, checking that no slot is taken. A design that ignored the limit would overwrite a live checkpoint. It then completes returns out of program order. A design that freed on any correct compare would release a slot whose older neighbours could still roll back.

The bench also forces a mismatch in the middle of the outstanding ring. It checks that younger records become deaf to their returns and that the freed index is reused. A design that invalidated only the failing record would later free or roll back checkpoints of flushed work. Finally, a mismatch that lands during an entry sequence must cancel the pending forward and retire. A design that missed this would retire a load the pipeline has just discarded.

// File: rtl/elr_pkg.sv
package elr_pkg;

   // Phases of the early-retirement entry sequence.
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_TAKE   = 2'd1,
      SQ_SUPPLY = 2'd2,
      SQ_RETIRE = 2'd3
   } seq_state_e;

endpackage

// File: rtl/elr_tag_match.sv
// Associative lookup of a returning tag against the pending records.
module elr_tag_match #(
   parameter int N     = 4,
   parameter int TAG_W = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     live,
   input  logic [TAG_W-1:0] tags [N],
   input  logic             probe_valid,
   input  logic [TAG_W-1:0] probe_tag,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);

   logic [N-1:0] eq;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign eq[g] = probe_valid && live[g] && (tags[g] == probe_tag);
   end

   assign hit = |eq;

   always_comb begin
      hit_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/elr_pend_table.sv
// Ring of pending predictions; slot index doubles as checkpoint index.
module elr_pend_table #(
   parameter int N      = 4,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(N),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [DATA_W-1:0] alloc_pred,
   input  logic              ret_valid,
   input  logic [TAG_W-1:0]  ret_tag,
   input  logic [DATA_W-1:0] ret_data,
   output logic [IDX_W-1:0]  alloc_idx,
   output logic              full,
   output logic [CNT_W-1:0]  count,
   output logic              free_now,
   output logic [IDX_W-1:0]  free_idx,
   output logic              mis_now,
   output logic [IDX_W-1:0]  mis_idx
);

   logic [N-1:0]      live_q, done_q;
   logic [TAG_W-1:0]  tag_q  [N];
   logic [DATA_W-1:0] pred_q [N];
   logic [IDX_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0]  cnt_q, cnt_nxt;

   logic              hit;
   logic [IDX_W-1:0]  hit_idx;
   logic              cmp_eq, ok_set;
   logic [IDX_W-1:0]  mis_rel;
   logic [N-1:0]      kill;

   // Only records still waiting for their data take part in the lookup (R5).
   elr_tag_match #(.N(N), .TAG_W(TAG_W)) u_match (
      .live        (live_q & ~done_q),
      .tags        (tag_q),
      .probe_valid (ret_valid),
      .probe_tag   (ret_tag),
      .hit         (hit),
      .hit_idx     (hit_idx)
   );

   assign cmp_eq   = (pred_q[hit_idx] == ret_data);
   assign ok_set   = hit && cmp_eq;
   assign mis_now  = hit && !cmp_eq;
   assign mis_idx  = hit_idx;

   // In-order release: only the oldest record, once it is good (R6).
   assign free_now = (cnt_q != '0) && done_q[head_q];
   assign free_idx = head_q;

   assign alloc_idx = tail_q;
   assign full      = (cnt_q == CNT_W'(N));
   assign count     = cnt_q;

   // Distance of the failing record from the oldest one; all records at or
   // beyond that distance are younger and die with it (R8).
   assign mis_rel = mis_idx - head_q;

   always_comb begin
      for (int j = 0; j < N; j++) begin
         kill[j] = mis_now && ((IDX_W'(j) - head_q) >= mis_rel);
      end
   end

   always_comb begin
      if (mis_now) begin
         cnt_nxt = {1'b0, mis_rel} - CNT_W'(free_now);
      end else begin
         cnt_nxt = cnt_q + CNT_W'(alloc_en) - CNT_W'(free_now);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         done_q <= '0;
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         for (int j = 0; j < N; j++) begin
            tag_q[j]  <= '0;
            pred_q[j] <= '0;
         end
      end else begin
         live_q <= live_q & ~kill;
         done_q <= done_q & ~kill;
         if (ok_set) done_q[hit_idx] <= 1'b1;
         if (free_now) begin
            live_q[head_q] <= 1'b0;
            done_q[head_q] <= 1'b0;
            head_q         <= head_q + 1'b1;
         end
         if (mis_now) begin
            tail_q <= mis_idx;
         end else if (alloc_en) begin
            live_q[tail_q] <= 1'b1;
            done_q[tail_q] <= 1'b0;
            tag_q[tail_q]  <= alloc_tag;
            pred_q[tail_q] <= alloc_pred;
            tail_q         <= tail_q + 1'b1;
         end
         cnt_q <= cnt_nxt;
      end
   end

endmodule

// File: rtl/elr_seq.sv
// Entry sequencer: checkpoint, then forward prediction, then early retire.
module elr_seq
   import elr_pkg::*;
#(
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qualify,
   input  logic              full,
   input  logic              abort,
   input  logic              block,
   input  logic [TAG_W-1:0]  head_tag,
   input  logic [DATA_W-1:0] head_pred,
   output logic              take,
   output logic              supply,
   output logic              retire,
   output logic              hold,
   output logic [TAG_W-1:0]  lat_tag,
   output logic [DATA_W-1:0] lat_pred
);

   seq_state_e st_q, st_nxt;
   logic       start;

   assign start = (st_q == SQ_IDLE) && qualify && !full && !abort && !block;

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         SQ_IDLE:   if (start) st_nxt = SQ_TAKE;
         SQ_TAKE:   st_nxt = abort ? SQ_IDLE : SQ_SUPPLY;
         SQ_SUPPLY: st_nxt = abort ? SQ_IDLE : SQ_RETIRE;
         SQ_RETIRE: st_nxt = SQ_IDLE;
         default:   st_nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         lat_tag  <= '0;
         lat_pred <= '0;
      end else begin
         st_q <= st_nxt;
         if (start) begin
            lat_tag  <= head_tag;
            lat_pred <= head_pred;
         end
      end
   end

   // A rollback in flight cancels the remaining steps (R10).
   assign take   = (st_q == SQ_TAKE)   && !abort;
   assign supply = (st_q == SQ_SUPPLY) && !abort;
   assign retire = (st_q == SQ_RETIRE) && !abort;
   // Hold the head while sequencing, or when no slot is free (R3).
   assign hold   = (st_q != SQ_IDLE) || (qualify && full);

endmodule

// File: rtl/elr_top.sv
module elr_top #(
   parameter int NUM_CKPT = 4,
   parameter int TAG_W    = 8,
   parameter int DATA_W   = 32,
   localparam int IDX_W   = $clog2(NUM_CKPT),
   localparam int CNT_W   = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic              head_is_load,
   input  logic              head_long_lat,
   input  logic              head_resolved,
   input  logic [TAG_W-1:0]  head_tag,
   input  logic [DATA_W-1:0] head_pred,
   output logic              hold_head,
   output logic              ckpt_take,
   output logic [IDX_W-1:0]  ckpt_take_idx,
   output logic              fwd_valid,
   output logic [TAG_W-1:0]  fwd_tag,
   output logic [DATA_W-1:0] fwd_value,
   output logic              retire_early,
   input  logic              ret_valid,
   input  logic [TAG_W-1:0]  ret_tag,
   input  logic [DATA_W-1:0] ret_data,
   output logic              ckpt_free,
   output logic [IDX_W-1:0]  ckpt_free_idx,
   output logic              rollback,
   output logic [IDX_W-1:0]  rollback_idx,
   output logic              flush,
   output logic              spec_mode
);

   if (NUM_CKPT < 2 || (NUM_CKPT & (NUM_CKPT - 1)) != 0) begin : g_bad_depth
      $error("elr_top: NUM_CKPT must be a power of two, at least 2");
   end
   if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("elr_top: TAG_W and DATA_W must be positive");
   end

   logic              qualify;
   logic              full;
   logic [CNT_W-1:0]  outstanding;
   logic              mis_now;
   logic [IDX_W-1:0]  mis_idx;
   logic              take;
   logic [TAG_W-1:0]  lat_tag;
   logic [DATA_W-1:0] lat_pred;
   logic              rb_q;
   logic [IDX_W-1:0]  rb_idx_q;

   // Entry condition (R1).
   assign qualify = head_valid && head_is_load && head_long_lat && !head_resolved;

   elr_seq #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .qualify   (qualify),
      .full      (full),
      .abort     (mis_now),
      .block     (rb_q),
      .head_tag  (head_tag),
      .head_pred (head_pred),
      .take      (take),
      .supply    (fwd_valid),
      .retire    (retire_early),
      .hold      (hold_head),
      .lat_tag   (lat_tag),
      .lat_pred  (lat_pred)
   );

   elr_pend_table #(.N(NUM_CKPT), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_tab (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (take),
      .alloc_tag  (lat_tag),
      .alloc_pred (lat_pred),
      .ret_valid  (ret_valid),
      .ret_tag    (ret_tag),
      .ret_data   (ret_data),
      .alloc_idx  (ckpt_take_idx),
      .full       (full),
      .count      (outstanding),
      .free_now   (ckpt_free),
      .free_idx   (ckpt_free_idx),
      .mis_now    (mis_now),
      .mis_idx    (mis_idx)
   );

   // Registered one-cycle rollback request with its flush (R7).
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rb_q     <= 1'b0;
         rb_idx_q <= '0;
      end else begin
         rb_q     <= mis_now;
         rb_idx_q <= mis_idx;
      end
   end

   assign ckpt_take    = take;
   assign fwd_tag      = lat_tag;
   assign fwd_value    = lat_pred;
   assign rollback     = rb_q;
   assign rollback_idx = rb_idx_q;
   assign flush        = rb_q;
   assign spec_mode    = (outstanding != '0);

endmodule

// File: rtl/elr_chk.sv
module elr_chk #(
   parameter int NUM_CKPT = 4,
   localparam int IDX_W   = $clog2(NUM_CKPT),
   localparam int CNT_W   = IDX_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             head_valid,
   input logic             head_is_load,
   input logic             head_long_lat,
   input logic             head_resolved,
   input logic             hold_head,
   input logic             ckpt_take,
   input logic             fwd_valid,
   input logic             retire_early,
   input logic             ret_valid,
   input logic             ckpt_free,
   input logic             rollback,
   input logic             spec_mode,
   input logic [CNT_W-1:0] outstanding
);

   logic head_q;
   assign head_q = head_valid && head_is_load && head_long_lat && !head_resolved;

   p_take_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ckpt_take |-> $past(head_q));

   p_fwd_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(ckpt_take));

   p_retire_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      retire_early |-> $past(fwd_valid));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= CNT_W'(NUM_CKPT));

   p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (head_q && outstanding == CNT_W'(NUM_CKPT)) |-> (hold_head && !ckpt_take));

   p_free_in_spec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ckpt_free |-> spec_mode);

   p_rb_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rollback |-> $past(ret_valid));

   p_take_spec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ckpt_take |=> spec_mode);

   p_rb_no_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rollback |-> (!retire_early && !ckpt_take));

endmodule

bind elr_top elr_chk #(.NUM_CKPT(NUM_CKPT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .head_valid    (head_valid),
   .head_is_load  (head_is_load),
   .head_long_lat (head_long_lat),
   .head_resolved (head_resolved),
   .hold_head     (hold_head),
   .ckpt_take     (ckpt_take),
   .fwd_valid     (fwd_valid),
   .retire_early  (retire_early),
   .ret_valid     (ret_valid),
   .ckpt_free     (ckpt_free),
   .rollback      (rollback),
   .spec_mode     (spec_mode),
   .outstanding   (outstanding)
);

// File: tb/tb_elr_top.sv
module tb_elr_top;

   localparam int K_TAKE = 0;
   localparam int K_FWD  = 1;
   localparam int K_RET  = 2;
   localparam int K_FREE = 3;
   localparam int K_RB   = 4;

   typedef struct {
      int     kind;
      int     idx;
      int     tag;
      longint val;
      string  req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        head_valid = 1'b0, head_is_load = 1'b0, head_long_lat = 1'b0, head_resolved = 1'b0;
   logic [7:0]  head_tag = '0;
   logic [31:0] head_pred = '0;
   logic        hold_head, ckpt_take, fwd_valid, retire_early;
   logic [1:0]  ckpt_take_idx, ckpt_free_idx, rollback_idx;
   logic [7:0]  fwd_tag;
   logic [31:0] fwd_value;
   logic        ret_valid = 1'b0;
   logic [7:0]  ret_tag = '0;
   logic [31:0] ret_data = '0;
   logic        ckpt_free, rollback, flush, spec_mode;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   elr_top dut (
      .clk(clk), .rst_n(rst_n),
      .head_valid(head_valid), .head_is_load(head_is_load),
      .head_long_lat(head_long_lat), .head_resolved(head_resolved),
      .head_tag(head_tag), .head_pred(head_pred),
      .hold_head(hold_head), .ckpt_take(ckpt_take), .ckpt_take_idx(ckpt_take_idx),
      .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_value(fwd_value),
      .retire_early(retire_early),
      .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
      .ckpt_free(ckpt_free), .ckpt_free_idx(ckpt_free_idx),
      .rollback(rollback), .rollback_idx(rollback_idx), .flush(flush),
      .spec_mode(spec_mode)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input int k, input int idx, input int tag, input longint val, input string req);
      exp_t e;
      e.kind = k; e.idx = idx; e.tag = tag; e.val = val; e.req = req;
      q.push_back(e);
   endtask

   // Monitor side of the scoreboard.
   task automatic see(input int k, input int idx, input int tag, input longint val);
      exp_t e;
      checks++;
      if (q.size() == 0) begin
         errors++;
         $display("FAIL unexpected event: actual kind %0d idx %0d expected none", k, idx);
      end else begin
         e = q.pop_front();
         if (e.kind != k || e.idx != idx || e.tag != tag || e.val != val) begin
            errors++;
            $display("FAIL %s: actual kind %0d idx %0d tag %0d val %0d expected kind %0d idx %0d tag %0d val %0d",
                     e.req, k, idx, tag, val, e.kind, e.idx, e.tag, e.val);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (ckpt_take)    see(K_TAKE, int'(ckpt_take_idx), 0, 0);
         if (fwd_valid)    see(K_FWD, 0, int'(fwd_tag), longint'(fwd_value));
         if (retire_early) see(K_RET, 0, 0, 0);
         if (ckpt_free)    see(K_FREE, int'(ckpt_free_idx), 0, 0);
         if (rollback)     see(K_RB, int'(rollback_idx), int'(flush), 0);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic set_head(input logic v, input logic ld, input logic ll, input logic rs,
                           input logic [7:0] tg, input logic [31:0] pv);
      head_valid = v; head_is_load = ld; head_long_lat = ll; head_resolved = rs;
      head_tag = tg; head_pred = pv;
   endtask

   // Driver: one full entry sequence with expected events pushed (R2, R4).
   task automatic launch(input logic [7:0] tg, input logic [31:0] pv, input int idx);
      push(K_TAKE, idx, 0, 0, "R4");
      push(K_FWD, 0, int'(tg), longint'(pv), "R2");
      push(K_RET, 0, 0, 0, "R2");
      set_head(1'b1, 1'b1, 1'b1, 1'b0, tg, pv);
      tick();
      chk(hold_head == 1'b1, "R2 hold in take", int'(hold_head), 1);
      tick();
      chk(hold_head == 1'b1, "R2 hold in supply", int'(hold_head), 1);
      tick();
      chk(hold_head == 1'b1, "R2 hold in retire", int'(hold_head), 1);
      head_valid = 1'b0;
      tick();
      chk(hold_head == 1'b0, "R2 hold released", int'(hold_head), 0);
   endtask

   task automatic ret(input logic [7:0] tg, input logic [31:0] d);
      ret_valid = 1'b1; ret_tag = tg; ret_data = d;
      tick();
      ret_valid = 1'b0;
   endtask

   initial begin
      idle(3);
      // R11: reset state
      chk({hold_head, ckpt_take, fwd_valid, retire_early, ckpt_free, rollback, flush, spec_mode} == 8'h00,
          "R11 reset outputs", 0, 0);
      rst_n = 1'b1;
      tick();

      // R1: non-qualifying heads do nothing
      set_head(1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 32'd1);
      idle(2);
      chk(!ckpt_take && !hold_head, "R1 resolved load", int'(ckpt_take), 0);
      set_head(1'b1, 1'b1, 1'b0, 1'b0, 8'h02, 32'd2);
      idle(2);
      chk(!ckpt_take && !hold_head, "R1 short-latency load", int'(ckpt_take), 0);
      set_head(1'b1, 1'b0, 1'b1, 1'b0, 8'h03, 32'd3);
      idle(2);
      chk(!ckpt_take && !hold_head, "R1 non-load", int'(ckpt_take), 0);
      set_head(1'b0, 1'b1, 1'b1, 1'b0, 8'h04, 32'd4);
      idle(2);
      chk(spec_mode == 1'b0, "R1 no entry", int'(spec_mode), 0);

      // Basic correct prediction
      launch(8'h11, 32'hA5A5_0001, 0);
      chk(spec_mode == 1'b1, "R9 spec after take", int'(spec_mode), 1);
      push(K_FREE, 0, 0, 0, "R6");
      ret(8'h11, 32'hA5A5_0001);
      idle(2);
      chk(spec_mode == 1'b0, "R9 spec cleared", int'(spec_mode), 0);

      // Fill all slots: ring order 1,2,3,0 (R4)
      launch(8'h21, 32'd100, 1);
      launch(8'h22, 32'd200, 2);
      launch(8'h23, 32'd300, 3);
      launch(8'h24, 32'd400, 0);
      // R3: fifth load stalls
      set_head(1'b1, 1'b1, 1'b1, 1'b0, 8'h25, 32'd500);
      tick();
      chk(hold_head == 1'b1, "R3 hold when full", int'(hold_head), 1);
      idle(2);
      chk(!ckpt_take && hold_head, "R3 no take when full", int'(ckpt_take), 0);
      head_valid = 1'b0;
      tick();

      // R6: younger good record waits for older
      ret(8'h22, 32'd200);
      idle(2);
      chk(ckpt_free == 1'b0, "R6 no out-of-order free", int'(ckpt_free), 0);
      push(K_FREE, 1, 0, 0, "R6");
      push(K_FREE, 2, 0, 0, "R6");
      ret(8'h21, 32'd100);
      idle(3);
      launch(8'h25, 32'd500, 1);

      // Outstanding now: 3 (0x23), 0 (0x24), 1 (0x25). Mismatch on slot 0.
      push(K_RB, 0, 1, 0, "R7");
      ret(8'h24, 32'd401);
      chk(rollback == 1'b1 && flush == 1'b1, "R7 rollback pulse", int'(rollback), 1);
      tick();
      chk(rollback == 1'b0, "R7 single cycle", int'(rollback), 0);
      chk(spec_mode == 1'b1, "R9 older survives", int'(spec_mode), 1);
      // R8: killed younger record ignores returns
      ret(8'h25, 32'd500);
      ret(8'h25, 32'd9);
      idle(2);
      chk(!ckpt_free && !rollback, "R8 killed record deaf", int'(ckpt_free), 0);
      // R8: index reuse
      launch(8'h26, 32'd600, 0);
      ret(8'h26, 32'd600);
      idle(1);
      push(K_FREE, 3, 0, 0, "R6");
      push(K_FREE, 0, 0, 0, "R6");
      ret(8'h23, 32'd300);
      idle(3);
      chk(spec_mode == 1'b0, "R9 all freed", int'(spec_mode), 0);

      // R5: unknown tag ignored
      launch(8'h31, 32'd700, 1);
      ret(8'h77, 32'd700);
      idle(2);
      chk(spec_mode == 1'b1 && !ckpt_free && !rollback, "R5 unknown tag", int'(spec_mode), 1);

      // R10: mismatch during take cycle cancels the sequence
      set_head(1'b1, 1'b1, 1'b1, 1'b0, 8'h32, 32'd800);
      tick();
      push(K_RB, 1, 1, 0, "R10");
      ret_valid = 1'b1; ret_tag = 8'h31; ret_data = 32'd1;
      #1;
      chk(ckpt_take == 1'b0, "R10 take cancelled", int'(ckpt_take), 0);
      tick();
      ret_valid = 1'b0;
      head_valid = 1'b0;
      idle(3);
      chk(spec_mode == 1'b0, "R10 nothing outstanding", int'(spec_mode), 0);
      launch(8'h33, 32'd900, 1);
      push(K_FREE, 1, 0, 0, "R6");
      ret(8'h33, 32'd900);
      idle(3);

      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL %s: actual %0d missing events expected 0", q[0].req, q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule